// File: doc/BRIEF.md
# Video Status and HV-Counter Read Port

This block builds the two words a CPU sees when it reads the control side of a video display processor. The status word is a 16-bit value. Most of its bits come straight from a stored status register. Three positions are computed live:

- a horizontal-blank flag, worked out from the current cycle position within the scanline;
- a FIFO-empty flag and a FIFO-full flag, worked out from the number of pending data-port writes.

While a DMA transfer is running, the FIFO flags are forced to report empty.

The HV word carries the horizontal count in its low byte and the vertical count in its high byte. When a latch-enable bit goes from 0 to 1, the current HV value is frozen into a hold register. From then on, HV reads return the frozen copy until the bit is cleared.

The block also tracks whether a two-part control command has had only its first half written. A status read drops that half-written mark.

The two small state machines are:

- Command tracker, states `CMD_IDLE` and `CMD_HALF`. A first-half write moves it IDLE→HALF. A status read moves it HALF→IDLE. A first-half write in HALF keeps it in HALF.
- HV tracker, states `HV_LIVE` and `HV_HELD`. LIVE→HELD happens with a capture when the latch bit is seen set. HELD→LIVE happens when the bit is seen clear.

Top module: `vid_status_port`

## Requirements
- R1: With `wide_mode`=1, status bit 2 (horizontal blank) is 1 exactly when `line_cycle` is in 32..125 inclusive, and 0 for every other cycle.
- R2: With `wide_mode`=0, status bit 2 is 1 exactly when `line_cycle` is in 40..123 inclusive, and 0 otherwise.
- R3: While `dma_busy`=1, status bit 9 (empty) is 1 and status bit 8 (full) is 0, whatever `fifo_pending` holds.
- R4: While `dma_busy`=0, bit 8 is 1 when `fifo_pending` ≥ 4, bit 9 is 1 when `fifo_pending` = 0, and both are 0 for 1..3.
- R5: Status bits 9 and 8 are never 1 together.
- R6: Every status bit other than 9, 8 and 2 equals the same bit of `stat_in`, in the same cycle.
- R7: `cmd_pending` becomes 1 on the clock after a `cmd_first_wr`. It becomes 0 on the clock after a `status_rd` that has no `cmd_first_wr` in the same cycle. When both come in one cycle, the write wins and `cmd_pending` is 1 afterwards.
- R8: In the first cycle `latch_en` is seen at 1 after being 0 (or after reset), the value {`vcount`,`hcount`} is captured. From the next cycle on, while `latch_en` stays 1, `hv_word` holds that captured value even as the counters move.
- R9: While `latch_en`=0, `hv_word` equals {`vcount`,`hcount`} in the same cycle.
- R10: After reset, `cmd_pending` is 0 and the HV tracker is live.
- R11: Clearing `latch_en` and setting it again captures a fresh value. The old frozen value is not returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cycle | input | 9 | CPU cycle position within the current scanline |
| wide_mode | input | 1 | 1 selects the wide (more columns) horizontal timing |
| hcount | input | 8 | Live horizontal count |
| vcount | input | 8 | Live vertical count |
| latch_en | input | 1 | HV latch-enable register bit |
| dma_busy | input | 1 | A DMA transfer is in progress |
| fifo_pending | input | 4 | Number of pending data-port writes |
| stat_in | input | 16 | Stored status bits passed through |
| status_rd | input | 1 | Status word is being read this cycle |
| cmd_first_wr | input | 1 | First half of a control command written this cycle |
| status_word | output | 16 | Composed status word |
| hv_word | output | 16 | HV counter word, live or frozen |
| cmd_pending | output | 1 | A command is half written |

## Verification
A status read and a first-half command write can land in the same cycle. Both drive the command tracker, one toward IDLE and one toward HALF. The bench forces the two strobes together, both from IDLE and from HALF, and also lets them coincide at random. On the following clock it expects `cmd_pending` set. A second overlap is a rising latch bit in the same cycle as moving counters. The bench changes `hcount` and `vcount` on every cycle around the edge and expects the value present in the capture cycle to be held.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
    // Status bit positions decoded by software.
    localparam int SB_EMPTY = 9;
    localparam int SB_FULL  = 8;
    localparam int SB_HBLK  = 2;

    typedef enum logic {CMD_IDLE, CMD_HALF} cmd_state_t;
    typedef enum logic {HV_LIVE, HV_HELD} hv_state_t;
endpackage

// File: rtl/hblank_detect.sv
module hblank_detect #(
    parameter int CYC_W      = 9,
    parameter int WIDE_OFF   = 32,
    parameter int WIDE_LEN   = 94,
    parameter int NARROW_OFF = 40,
    parameter int NARROW_LEN = 84
) (
    input  logic [CYC_W-1:0] line_cycle,
    input  logic             wide_mode,
    output logic             hblank
);
    localparam int REL_W = CYC_W + 1;

    logic [REL_W-1:0] off_sel;
    logic [REL_W-1:0] len_sel;
    logic [REL_W-1:0] rel;

    always_comb begin
        off_sel = wide_mode ? REL_W'(WIDE_OFF) : REL_W'(NARROW_OFF);
        len_sel = wide_mode ? REL_W'(WIDE_LEN) : REL_W'(NARROW_LEN);
        rel     = {1'b0, line_cycle} - off_sel;
        hblank  = ({1'b0, line_cycle} >= off_sel) && (rel < len_sel);
    end
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags #(
    parameter int CNT_W      = 4,
    parameter int FULL_LEVEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_busy,
    input  logic [CNT_W-1:0] pending,
    output logic             flag_empty,
    output logic             flag_full
);
    localparam logic [CNT_W-1:0] FULL_AT = CNT_W'(FULL_LEVEL);

    always_comb begin
        if (dma_busy) begin
            flag_empty = 1'b1;
            flag_full  = 1'b0;
        end else begin
            flag_empty = (pending == '0);
            flag_full  = (pending >= FULL_AT);
        end
    end

    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_empty && flag_full));

    // R3
    dma_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> (flag_empty && !flag_full));
endmodule

// File: rtl/cmd_pending_fsm.sv
module cmd_pending_fsm
    import vstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_wr,
    input  logic status_rd,
    output logic pending
);
    cmd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (first_wr)                state_d = CMD_HALF;
            CMD_HALF: if (status_rd && !first_wr)  state_d = CMD_IDLE;
            default:                               state_d = CMD_IDLE;
        endcase
    end

    always_comb pending = (state_q == CMD_HALF);

    // R7
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !first_wr) |=> !pending);

    // R7
    cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> pending);
endmodule

// File: rtl/hv_latch_unit.sv
module hv_latch_unit
    import vstat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               latch_en,
    input  logic [CNT_W-1:0]   hcount,
    input  logic [CNT_W-1:0]   vcount,
    output logic [2*CNT_W-1:0] hv_word
);
    localparam int HV_W = 2 * CNT_W;

    hv_state_t        state_q, state_d;
    logic [HV_W-1:0]  held_q;
    logic [HV_W-1:0]  live_val;
    logic             capture;

    always_comb live_val = {vcount, hcount};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HV_LIVE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) held_q <= live_val;
        end
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            HV_LIVE: if (latch_en) begin
                state_d = HV_HELD;
                capture = 1'b1;
            end
            HV_HELD: if (!latch_en) state_d = HV_LIVE;
            default: state_d = HV_LIVE;
        endcase
    end

    always_comb hv_word = (latch_en && state_q == HV_HELD) ? held_q : live_val;

    // R8
    hv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (!latch_en || $stable(hv_word)));
endmodule

// File: rtl/vid_status_port.sv
module vid_status_port
    import vstat_pkg::*;
#(
    parameter int CYC_W      = 9,
    parameter int CNT_W      = 8,
    parameter int FIFO_W     = 4,
    parameter int FULL_LEVEL = 4,
    parameter int SW_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CYC_W-1:0]    line_cycle,
    input  logic                wide_mode,
    input  logic [CNT_W-1:0]    hcount,
    input  logic [CNT_W-1:0]    vcount,
    input  logic                latch_en,
    input  logic                dma_busy,
    input  logic [FIFO_W-1:0]   fifo_pending,
    input  logic [SW_W-1:0]     stat_in,
    input  logic                status_rd,
    input  logic                cmd_first_wr,
    output logic [SW_W-1:0]     status_word,
    output logic [2*CNT_W-1:0]  hv_word,
    output logic                cmd_pending
);
    logic hblank, f_empty, f_full;

    hblank_detect #(.CYC_W(CYC_W)) u_hblank (
        .line_cycle (line_cycle),
        .wide_mode  (wide_mode),
        .hblank     (hblank)
    );

    fifo_flags #(.CNT_W(FIFO_W), .FULL_LEVEL(FULL_LEVEL)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_busy   (dma_busy),
        .pending    (fifo_pending),
        .flag_empty (f_empty),
        .flag_full  (f_full)
    );

    cmd_pending_fsm u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .first_wr  (cmd_first_wr),
        .status_rd (status_rd),
        .pending   (cmd_pending)
    );

    hv_latch_unit #(.CNT_W(CNT_W)) u_hv (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .hcount   (hcount),
        .vcount   (vcount),
        .hv_word  (hv_word)
    );

    always_comb begin
        status_word           = stat_in;
        status_word[SB_EMPTY] = f_empty;
        status_word[SB_FULL]  = f_full;
        status_word[SB_HBLK]  = hblank;
    end
endmodule

// File: tb/vid_status_port_tb.sv
module vid_status_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  line_cycle = '0;
    logic        wide_mode = 1'b0;
    logic [7:0]  hcount = '0, vcount = '0;
    logic        latch_en = 1'b0, dma_busy = 1'b0;
    logic [3:0]  fifo_pending = '0;
    logic [15:0] stat_in = '0;
    logic        status_rd = 1'b0, cmd_first_wr = 1'b0;
    logic [15:0] status_word, hv_word;
    logic        cmd_pending;

    int checks = 0, fails = 0;
    logic        m_pend = 1'b0, m_held = 1'b0;
    logic [15:0] m_latch = '0;

    always #2 clk = ~clk;

    vid_status_port u_dut (
        .clk(clk), .rst_n(rst_n), .line_cycle(line_cycle), .wide_mode(wide_mode),
        .hcount(hcount), .vcount(vcount), .latch_en(latch_en), .dma_busy(dma_busy),
        .fifo_pending(fifo_pending), .stat_in(stat_in), .status_rd(status_rd),
        .cmd_first_wr(cmd_first_wr), .status_word(status_word), .hv_word(hv_word),
        .cmd_pending(cmd_pending)
    );

    function automatic logic exp_hbl(input logic [8:0] c, input logic w);
        int off = w ? 32 : 40;
        int len = w ? 94 : 84;
        return (int'(c) >= off) && (int'(c) - off < len);
    endfunction

    function automatic logic [1:0] exp_flags(input logic d, input logic [3:0] p);
        if (d) return 2'b10;
        return {p == 4'd0, p >= 4'd4};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        logic [15:0] hv_exp;
        check(wide_mode ? "R1" : "R2", {15'd0, status_word[2]}, {15'd0, exp_hbl(line_cycle, wide_mode)});
        check(dma_busy ? "R3" : "R4", {14'd0, status_word[9:8]}, {14'd0, exp_flags(dma_busy, fifo_pending)});
        check("R5", {15'd0, status_word[9] & status_word[8]}, 16'd0);
        check("R6", status_word & 16'hFCFB, stat_in & 16'hFCFB);
        hv_exp = (latch_en && m_held) ? m_latch : {vcount, hcount};
        check((latch_en && m_held) ? "R8" : "R9", hv_word, hv_exp);
        check("R7", {15'd0, cmd_pending}, {15'd0, m_pend});
    endtask

    // Check after inputs settle, clock, then update the model.
    task automatic tick();
        #1;
        check_outputs();
        @(posedge clk);
        if (cmd_first_wr) m_pend = 1'b1;
        else if (status_rd) m_pend = 1'b0;
        if (!m_held && latch_en) begin
            m_latch = {vcount, hcount};
            m_held  = 1'b1;
        end else if (!latch_en) m_held = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        latch_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R10", {15'd0, cmd_pending}, 16'd0);
        check("R10", hv_word, {vcount, hcount});
        latch_en = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 / R2: sweep the whole line in both modes
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 488; c++) begin
                wide_mode = w[0]; line_cycle = 9'(c);
                tick();
            end
        end

        // R3 / R4: every pending count with and without DMA
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 16; p++) begin
                dma_busy = d[0]; fifo_pending = 4'(p);
                tick();
            end
        end
        dma_busy = 1'b0; fifo_pending = '0;

        // R7: set, clear, and simultaneous read+write from both states
        cmd_first_wr = 1'b1; tick(); cmd_first_wr = 1'b0; tick();
        check("R7", {15'd0, cmd_pending}, 16'd1);
        status_rd = 1'b1; tick(); status_rd = 1'b0; tick();
        check("R7", {15'd0, cmd_pending}, 16'd0);
        status_rd = 1'b1; cmd_first_wr = 1'b1; tick();
        status_rd = 1'b0; cmd_first_wr = 1'b0; tick();
        check("R7", {15'd0, cmd_pending}, 16'd1);
        status_rd = 1'b1; cmd_first_wr = 1'b1; tick();
        status_rd = 1'b0; cmd_first_wr = 1'b0; tick();
        check("R7", {15'd0, cmd_pending}, 16'd1);

        // R8 / R11: capture with counters moving every cycle
        hcount = 8'h11; vcount = 8'h22; latch_en = 1'b1; tick();
        for (int i = 0; i < 5; i++) begin
            hcount = hcount + 8'd7; vcount = vcount + 8'd3; tick();
            check("R8", hv_word, 16'h2211);
        end
        latch_en = 1'b0; tick();
        hcount = 8'h5A; vcount = 8'hA5; latch_en = 1'b1; tick();
        hcount = 8'h00; vcount = 8'h00; tick();
        check("R11", hv_word, 16'hA55A);
        latch_en = 1'b0; tick();

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            line_cycle   = 9'($urandom_range(0, 487));
            wide_mode    = 1'($urandom);
            hcount       = 8'($urandom);
            vcount       = 8'($urandom);
            if ($urandom_range(0, 9) == 0) latch_en = ~latch_en;
            dma_busy     = ($urandom_range(0, 3) == 0);
            fifo_pending = 4'($urandom);
            stat_in      = 16'($urandom);
            status_rd    = 1'($urandom);
            cmd_first_wr = ($urandom_range(0, 2) == 0);
            tick();
        end

        summary();
        $finish;
    end
endmodule